// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes one operand request from inside the chip and carries it out on an external bus. The request is a byte, a word or a long word at a 24-bit address, and the external bus is 16 bits wide. The block splits the operand into bus cycles. For each cycle it drives the address, a size code and the write lanes. The responding device answers with an active-low two-bit acknowledge that gives its port width, 8 or 16 bits. The sequencer uses that width to decide how many bytes the current cycle moved. It then steps the address and the count of bytes still remaining, and issues further cycles until the whole operand has moved.

Reads are collected into a 32-bit result, right-aligned in big-endian order, and a one-cycle completion pulse marks the end. Two kinds of request are refused with a one-cycle error pulse and no bus cycle: a word or long word at an odd address, and the unused size code.

Top module: `dbs_sequencer`

## Requirements
- R1: When a request is accepted, the first bus cycle begins in the next clock cycle. It carries the full request address, bits [23:1] as the word base and bit 0 as the byte offset.
- R2: A request with `req_size` of 10 (word) or 00 (long) and `req_addr[0]`=1 is refused, and so is a request with `req_size`=11. The block pulses `err` for one cycle, in the cycle after the request, and `bus_cyc` stays low.
- R3: `bus_cyc` is high from the cycle after acceptance until the acknowledge of the last portion, and low in the cycle after that acknowledge. `busy` equals `bus_cyc`.
- R4: In every bus cycle, `bus_siz` encodes the bytes still remaining in the operand: 01 for one, 10 for two, 11 for three, 00 for four.
- R5: `bus_ack_n` is active-low. When bit 1 is low the port is 16 bits wide, whatever bit 0 is. The value 10 means an 8-bit port. The value 11 means wait.
- R6: An 8-bit port moves one byte per cycle. A 16-bit port moves two bytes when the address is even and at least two bytes remain, and one byte otherwise. The address advances by the number of bytes moved.
- R7: On writes, `bus_dout` is {first, second} remaining byte when the portion may be a word (even address, two or more bytes remaining). Otherwise it carries the next byte on both lanes.
- R8: While `bus_ack_n`=11, the address, size code and write data hold their values for the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the acknowledge of the last portion, and is low at all other times.
- R10: Read bytes are taken as follows. An 8-bit port supplies them on [15:8]. A 16-bit port supplies an even byte on [15:8] and an odd byte on [7:0], and a word as {even, odd}. The other lane is ignored. `rdata` holds the operand right-aligned and big-endian from the `done` cycle onward.
- R11: A long word over a 16-bit port takes two cycles. The first moves the most significant word at the request address. The second moves the least significant word at the address plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request, taken while not busy |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 01 byte, 10 word, 00 long |
| req_addr | input | 24 | Operand start address |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Request refused pulse |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 32 | Assembled read operand |
| bus_cyc | output | 1 | Bus cycle active |
| bus_wr | output | 1 | Bus cycle direction |
| bus_siz | output | 2 | Remaining-size code |
| bus_addr | output | 24 | Bus address |
| bus_dout | output | 16 | Write lanes |
| bus_din | input | 16 | Read lanes |
| bus_ack_n | input | 2 | Port-size acknowledge, active low |

## Verification
The acknowledge of the last portion does two things at the same clock edge: it captures the final byte or word into the result, and it ends the transfer by raising `done`. A wrong lane choice or a late shift therefore shows up only in the value of `rdata` during the `done` cycle. The bench provokes this with long and word reads over both port widths and with odd single-byte reads. The unused lane of each cycle carries a distinct junk value, so a lane error changes the result. In every one of these cases `rdata` is compared with the operand that the bench's memory model holds, in exactly the cycle `done` rises.

// File: rtl/dbs_sequencer.sv
module dbs_sequencer #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          err,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_cyc,
  output logic          bus_wr,
  output logic [1:0]    bus_siz,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_dout,
  input  logic [15:0]   bus_din,
  input  logic [1:0]    bus_ack_n
);
  logic          active, wr_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    rem_q;
  logic [31:0]   wsh, rsh;

  wire port16 = ~bus_ack_n[1];
  wire port8  = bus_ack_n[1] & ~bus_ack_n[0];
  wire ack    = active & (port16 | port8);
  wire one_w  = addr_q[0] | (rem_q == 3'd1);
  wire two    = port16 & ~one_w;
  wire [2:0] step = two ? 3'd2 : 3'd1;
  wire [7:0] rbyte = (port16 & addr_q[0]) ? bus_din[7:0] : bus_din[15:8];

  wire bad = (req_size == 2'b11) | ((req_size != 2'b01) & req_addr[0]);
  logic [2:0]  rem_init;
  logic [31:0] wsh_init;
  always_comb begin
    case (req_size)
      2'b01:   begin rem_init = 3'd1; wsh_init = {req_wdata[7:0], 24'd0}; end
      2'b10:   begin rem_init = 3'd2; wsh_init = {req_wdata[15:0], 16'd0}; end
      default: begin rem_init = 3'd4; wsh_init = req_wdata; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      wsh    <= '0;
      rsh    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          if (bad) begin
            err_q <= 1'b1;
          end else begin
            active <= 1'b1;
            wr_q   <= req_write;
            addr_q <= req_addr;
            rem_q  <= rem_init;
            wsh    <= wsh_init;
            rsh    <= '0;
          end
        end
      end else if (ack) begin
        addr_q <= addr_q + AW'(step);
        rem_q  <= rem_q - step;
        wsh    <= two ? {wsh[15:0], 16'd0} : {wsh[23:0], 8'd0};
        rsh    <= two ? {rsh[15:0], bus_din} : {rsh[23:0], rbyte};
        if (rem_q == step) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = active;
  assign bus_cyc  = active;
  assign bus_wr   = active & wr_q;
  assign bus_siz  = rem_q[1:0];
  assign bus_addr = addr_q;
  assign bus_dout = one_w ? {wsh[31:24], wsh[31:24]} : wsh[31:16];
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rsh;
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err,
  input logic          done,
  input logic          bus_cyc,
  input logic          bus_wr,
  input logic [1:0]    bus_siz,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_dout,
  input logic [1:0]    bus_ack_n
);
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_cyc); // R2
  AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && done)); // R9
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b11) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout))); // R8
  AST_BYTE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_wr && bus_siz == 2'b01) |-> bus_dout[15:8] == bus_dout[7:0]); // R7
  AST_LONG_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_siz == 2'b00 && !bus_ack_n[1]) |=>
      (bus_cyc && bus_siz == 2'b10 && bus_addr == $past(bus_addr) + AW'(2))); // R11
  AST_THREE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_siz == 2'b11) |-> bus_addr[0]); // R4
  AST_DONE_AFTER_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !bus_cyc); // R3
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .err(err), .done(done), .bus_cyc(bus_cyc),
  .bus_wr(bus_wr), .bus_siz(bus_siz), .bus_addr(bus_addr),
  .bus_dout(bus_dout), .bus_ack_n(bus_ack_n)
);

// File: tb/dbs_sequencer_tb.sv
module dbs_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b01;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, err, done, bus_cyc, bus_wr;
  logic [31:0] rdata;
  logic [1:0]  bus_siz;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic [1:0]  bus_ack_n = 2'b11;
  int tests = 0, fails = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  dbs_sequencer dut_i (.*);

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // pm: 0 = 8-bit port, 1 = 16-bit port, 2 = both acknowledge bits low
  task automatic xfer(bit w, logic [1:0] sz, logic [23:0] ad, logic [31:0] d, int pm, int waits);
    int n, idx, rem, step;
    logic [23:0] a;
    logic [7:0] ob [4];
    logic [31:0] er, ex16;
    bit wide;
    wide = (pm != 0);
    n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    for (int i = 0; i < 4; i++) ob[i] = (i < n) ? d[8*(n-1-i) +: 8] : 8'h00;
    er = 0;
    for (int i = 0; i < n; i++) er = (er << 8) | 32'(mem[8'(ad + 24'(i))]);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = ad; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (sz == 2'b11 || (sz != 2'b01 && ad[0])) begin
      chk(err === 1'b1, "R2 err", 32'(err), 1);
      chk(bus_cyc === 1'b0, "R2 no cycle", 32'(bus_cyc), 0);
      @(negedge clk);
      chk(err === 1'b0 && bus_cyc === 1'b0, "R2 pulse", {err, bus_cyc}, 0);
      return;
    end
    a = ad; rem = n; idx = 0;
    while (rem > 0) begin
      chk(bus_cyc === 1'b1 && busy === 1'b1, "R3 cycle", 32'(bus_cyc), 1);
      chk(bus_addr === a, idx == 0 ? "R1" : (wide && n == 4) ? "R11" : (pm == 2) ? "R5" : "R6",
          32'(bus_addr), 32'(a));
      chk(bus_siz === 2'(rem), "R4 size", 32'(bus_siz), 32'(2'(rem)));
      chk(done === 1'b0, "R9 early", 32'(done), 0);
      if (w) begin
        ex16 = (a[0] || rem == 1) ? {16'd0, ob[idx], ob[idx]} : {16'd0, ob[idx], ob[idx+1]};
        chk(bus_dout === ex16[15:0], "R7 lanes", 32'(bus_dout), ex16);
      end
      for (int k = 0; k < waits; k++) begin
        bus_ack_n = 2'b11;
        @(negedge clk);
        chk(bus_cyc === 1'b1 && bus_addr === a && bus_siz === 2'(rem), "R8 hold",
            32'(bus_addr), 32'(a));
      end
      step = (!wide || a[0] || rem == 1) ? 1 : 2;
      if (wide) begin
        bus_ack_n = (pm == 2) ? 2'b00 : 2'b01;
        bus_din = {mem[{a[7:1], 1'b0}], mem[{a[7:1], 1'b1}]};
      end else begin
        bus_ack_n = 2'b10;
        bus_din = {mem[a[7:0]], 8'hC3};
      end
      if (w) for (int s = 0; s < step; s++) mem[8'(a + 24'(s))] = ob[idx+s];
      @(negedge clk);
      bus_ack_n = 2'b11;
      bus_din = 16'hDEAD;
      a = a + 24'(step); idx += step; rem -= step;
    end
    chk(done === 1'b1, "R9 done", 32'(done), 1);
    chk(bus_cyc === 1'b0 && busy === 1'b0, "R3 end", 32'(bus_cyc), 0);
    if (!w) chk(rdata === er, "R10 rdata", rdata, er);
    @(negedge clk);
    chk(done === 1'b0, "R9 pulse", 32'(done), 0);
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(bus_cyc === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "R3 reset", {bus_cyc, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1, 2'b00, 24'h000010, 32'hA1B2C3D4, 1, 1);
    xfer(0, 2'b00, 24'h000010, 0, 1, 0);
    xfer(0, 2'b00, 24'h000020, 0, 0, 0);
    xfer(1, 2'b00, 24'h000040, 32'h11223344, 0, 2);
    xfer(0, 2'b00, 24'h000040, 0, 2, 0);
    xfer(0, 2'b10, 24'h000042, 0, 0, 1);
    xfer(1, 2'b10, 24'h000050, 32'h0000BEEF, 2, 0);
    xfer(1, 2'b01, 24'h000061, 32'h0000005A, 1, 0);
    xfer(0, 2'b01, 24'h000061, 0, 1, 0);
    xfer(0, 2'b01, 24'h000060, 0, 1, 0);
    xfer(0, 2'b01, 24'h000033, 0, 0, 1);
    xfer(1, 2'b01, 24'h000070, 32'h000000E7, 0, 0);
    xfer(0, 2'b10, 24'h000031, 0, 1, 0);
    xfer(0, 2'b00, 24'h000033, 0, 0, 0);
    xfer(0, 2'b11, 24'h000034, 0, 1, 0);
    xfer(0, 2'b00, 24'h0000FE, 0, 1, 0);
    xfer(0, 2'b10, 24'h000050, 0, 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule